// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This block watches a running BCD calendar and raises an interrupt when the time reaches a programmed point. Six alarm values are held on chip: seconds, minutes, hours, day of month, month and a three-digit year. A control register holds one enable bit for each of these values and a global enable. The calendar itself is counted elsewhere. This block receives the current BCD fields and a one-cycle strobe that marks each new second.

On the cycle after the strobe, each enabled field is compared with its alarm value. The results are combined with OR, so a match on any single enabled field is enough. A hit sets a sticky pending flag, and the level interrupt follows that flag. Software clears the flag by writing a 1 to the status register. Software programs the registers through a simple write port and reads them back through a combinational read port.

The sequencer has three states:
- `ST_IDLE`: waiting for a strobe.
- `ST_EVAL`: the compare cycle.
- `ST_RAISED`: an alarm is pending.

Its transitions are:
- `ST_IDLE` goes to `ST_EVAL` on a strobe.
- `ST_EVAL` goes to `ST_RAISED` on a gated hit. With no hit, it goes to `ST_EVAL` again if a new strobe is present, and to `ST_IDLE` otherwise.
- `ST_RAISED` goes to `ST_IDLE` on a clear write. If the clear write comes with a strobe, it goes to `ST_EVAL` instead.

Top module: `cal_alarm_top`

## Requirements
- R1: After reset, every register reads 0, `alarm_irq` is low and status bit 1 reads 0.
- R2: Control bit 6 is the global enable. While it is 0, no field match raises the alarm.
- R3: Control bits 0..5 enable the comparison of seconds, minutes, hours, day, month and year, in that order. A match on a field whose bit is 0 does not raise the alarm.
- R4: Enabled matches are combined with OR. One enabled matching field raises the alarm even when every other enabled field mismatches.
- R5: Comparison happens only in the cycle after `sec_tick` is sampled high. `alarm_irq` rises at the second rising edge after the strobe is sampled. With no strobe, matching values never raise it.
- R6: Written alarm values are masked to their widths: seconds and minutes 7 bits, hours and day 6 bits, month 5 bits, year 12 bits. The address map is: 0 control, 1 seconds, 2 minutes, 3 hours, 4 day, 5 month, 6 year, 7 status. Reads return the stored value zero-extended.
- R7: The year compares all 12 bits: hundreds digit in bits [11:8], tens and units in bits [7:0]. A difference only in the hundreds digit is a mismatch.
- R8: The month compares the input BCD month (1..12) directly against the stored month, with no offset.
- R9: The pending flag is sticky and `alarm_irq` is a level that follows it. Writing data with bit 1 set to address 7 clears it. Writing only bit 0 leaves it set. Status reads show the flag in bit 1.
- R10: A clear write that coincides with a strobe starts a new comparison, so a still-matching time raises the alarm again one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle strobe after the time has advanced |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_day | input | 8 | Current day of month, BCD |
| cur_mon | input | 8 | Current month, BCD 1..12 |
| cur_year | input | 12 | Current year, 3-digit BCD |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 12 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 12 | Read data, combinational |
| alarm_irq | output | 1 | Level alarm interrupt |

## Verification
A sequencer stuck in `ST_EVAL` or `ST_RAISED` shows at the ports within one strobe period: either `alarm_irq` rises with no strobe, or it fails to drop after a clear write. A wrong enable bit or a wrong OR reduction shows on the next strobe as a wrong `alarm_irq` level. The sweep visits every field with its enable on and off, matching and not matching, and with the global enable on and off. Masking errors and field mix-ups show at once in `rd_data` after a write.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
    localparam int NUM_FIELDS  = 6;
    localparam int DATA_W      = 12;
    localparam int ADDR_W      = 3;
    localparam int CMP_W       = 12;
    localparam int GLOBAL_BIT  = 6;
    localparam int CTRL_W      = GLOBAL_BIT + 1;
    localparam int PEND_BIT    = 1;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_STATUS = 3'd7;

    typedef enum logic [1:0] {ST_IDLE, ST_EVAL, ST_RAISED} alm_state_e;

    // stored width of each alarm field, index 0 = seconds .. 5 = year
    function automatic int field_width(input int idx);
        case (idx)
            0, 1:    return 7;
            2, 3:    return 6;
            4:       return 5;
            default: return 12;
        endcase
    endfunction
endpackage

// File: rtl/cal_alarm_field.sv
module cal_alarm_field #(
    parameter int W     = 7,
    parameter int CMP_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_sel,
    input  logic [W-1:0]     wr_val,
    input  logic [CMP_W-1:0] cur_val,
    output logic [CMP_W-1:0] stored,
    output logic             hit
);
    logic [W-1:0] val_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      val_q <= '0;
        else if (wr_sel) val_q <= wr_val;
    end

    always_comb begin
        stored = CMP_W'(val_q);
        hit    = (cur_val == stored);
    end

    assert_field_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel |=> (stored == CMP_W'($past(wr_val))));
endmodule

// File: rtl/cal_alarm_seq.sv
module cal_alarm_seq
    import cal_alarm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sec_tick,
    input  logic global_en,
    input  logic any_hit,
    input  logic clr_req,
    output logic pending
);
    alm_state_e state, nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (sec_tick) nxt = ST_EVAL;
            ST_EVAL: begin
                if (global_en && any_hit) nxt = ST_RAISED;
                else if (sec_tick)        nxt = ST_EVAL;
                else                      nxt = ST_IDLE;
            end
            ST_RAISED: if (clr_req) nxt = sec_tick ? ST_EVAL : ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb pending = (state == ST_RAISED);

    assert_eval_after_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EVAL) |-> $past(sec_tick));
    assert_rise_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> $past(global_en && any_hit));
    assert_fall_on_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pending) |-> $past(clr_req));
endmodule

// File: rtl/cal_alarm_top.sv
module cal_alarm_top
    import cal_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic [7:0]        cur_sec,
    input  logic [7:0]        cur_min,
    input  logic [7:0]        cur_hour,
    input  logic [7:0]        cur_day,
    input  logic [7:0]        cur_mon,
    input  logic [11:0]       cur_year,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              alarm_irq
);
    logic [CTRL_W-1:0]                 ctrl_q;
    logic [NUM_FIELDS-1:0][CMP_W-1:0]  cur_vec;
    logic [NUM_FIELDS-1:0][CMP_W-1:0]  fld_val;
    logic [NUM_FIELDS-1:0]             hit_vec;
    logic                              any_hit, clr_req, pending;

    always_comb begin
        cur_vec[0] = CMP_W'(cur_sec);
        cur_vec[1] = CMP_W'(cur_min);
        cur_vec[2] = CMP_W'(cur_hour);
        cur_vec[3] = CMP_W'(cur_day);
        cur_vec[4] = CMP_W'(cur_mon);
        cur_vec[5] = CMP_W'(cur_year);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           ctrl_q <= '0;
        else if (wr_en && wr_addr == A_CTRL)  ctrl_q <= wr_data[CTRL_W-1:0];
    end

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
        localparam int W = field_width(g);
        cal_alarm_field #(.W(W), .CMP_W(CMP_W)) u_fld (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_sel  (wr_en && (wr_addr == ADDR_W'(g + 1))),
            .wr_val  (wr_data[W-1:0]),
            .cur_val (cur_vec[g]),
            .stored  (fld_val[g]),
            .hit     (hit_vec[g])
        );
    end

    always_comb begin
        any_hit = |(hit_vec & ctrl_q[NUM_FIELDS-1:0]);
        clr_req = wr_en && (wr_addr == A_STATUS) && wr_data[PEND_BIT];
    end

    cal_alarm_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_tick  (sec_tick),
        .global_en (ctrl_q[GLOBAL_BIT]),
        .any_hit   (any_hit),
        .clr_req   (clr_req),
        .pending   (pending)
    );

    always_comb begin
        alarm_irq = pending;
        rd_data   = '0;
        if (rd_addr == A_CTRL)        rd_data = DATA_W'(ctrl_q);
        else if (rd_addr == A_STATUS) rd_data[PEND_BIT] = pending;
        else                          rd_data = fld_val[rd_addr - 1'b1];
    end

    assert_rise_needs_enabled_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_irq) |-> $past(ctrl_q[GLOBAL_BIT] && (|(ctrl_q[NUM_FIELDS-1:0] & hit_vec))));
endmodule

// File: tb/cal_alarm_top_test.sv
module cal_alarm_top_test;
    logic clk = 0, rst_n = 0, sec_tick = 0, wr_en = 0;
    logic [7:0] cur_sec = 0, cur_min = 0, cur_hour = 0, cur_day = 0, cur_mon = 0;
    logic [11:0] cur_year = 0, wr_data = 0, rd_data;
    logic [2:0] wr_addr = 0, rd_addr = 0;
    logic alarm_irq;
    int checks = 0, failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cal_alarm_top uut (.clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_day(cur_day),
        .cur_mon(cur_mon), .cur_year(cur_year), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .alarm_irq(alarm_irq));

    // alarm values and non-matching time values, index 0 = seconds .. 5 = year
    logic [11:0] alm_v [6] = '{12'h045, 12'h030, 12'h012, 12'h015, 12'h009, 12'h124};
    logic [11:0] off_v [6] = '{12'h044, 12'h031, 12'h013, 12'h016, 12'h010, 12'h125};
    int widths [6] = '{7, 7, 6, 6, 5, 12};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [11:0] d);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [11:0] d);
        rd_addr = a; #1; d = rd_data;
    endtask

    task automatic set_time(input logic [11:0] v [6]);
        cur_sec = v[0][7:0]; cur_min = v[1][7:0]; cur_hour = v[2][7:0];
        cur_day = v[3][7:0]; cur_mon = v[4][7:0]; cur_year = v[5];
    endtask

    // strobe, then return at the negedge after the compare edge
    task automatic tick();
        @(negedge clk); sec_tick = 1;
        @(negedge clk); sec_tick = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [11:0] d;
        logic [11:0] tv [6];
        repeat (3) @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d); check("R1 reset read", d, 0);
        end
        check("R1 irq after reset", alarm_irq, 0);
        rst_n = 1;
        @(negedge clk);

        // R6 masking and address map
        for (int f = 0; f < 6; f++) begin
            wr(3'(f + 1), 12'hFFF); rd(3'(f + 1), d);
            check("R6 mask all-ones", d, (1 << widths[f]) - 1);
            wr(3'(f + 1), 12'hA5A); rd(3'(f + 1), d);
            check("R6 mask pattern", d, 12'hA5A & ((1 << widths[f]) - 1));
        end
        wr(0, 12'hFFF); rd(0, d); check("R6 control width", d, 12'h07F);

        for (int f = 0; f < 6; f++) wr(3'(f + 1), alm_v[f]);

        // R2 R3 R4 sweep: field, enable, match, global
        for (int f = 0; f < 6; f++)
            for (int en = 0; en < 2; en++)
                for (int m = 0; m < 2; m++)
                    for (int gl = 0; gl < 2; gl++) begin
                        logic [11:0] c;
                        bit expv;
                        tv = off_v;
                        if (m != 0) tv[f] = alm_v[f];
                        set_time(tv);
                        c = (12'h03F & ~(12'h1 << f)) | (en != 0 ? (12'h1 << f) : 12'h0)
                            | (gl != 0 ? 12'h040 : 12'h0);
                        wr(0, c);
                        tick();
                        expv = (gl != 0) && (en != 0) && (m != 0);
                        if (gl == 0) check("R2 global gate", alarm_irq, expv);
                        else if (en == 0) check("R3 field enable", alarm_irq, expv);
                        else check("R4 single-field OR", alarm_irq, expv);
                        wr(7, 12'h002);
                        check("R9 cleared", alarm_irq, 0);
                    end

        // R5 timing and no strobe
        tv = off_v; tv[0] = alm_v[0]; set_time(tv);
        wr(0, 12'h07F);
        repeat (5) @(negedge clk);
        check("R5 no strobe no alarm", alarm_irq, 0);
        @(negedge clk); sec_tick = 1;
        @(negedge clk); sec_tick = 0;
        check("R5 low during compare cycle", alarm_irq, 0);
        @(negedge clk);
        check("R5 high at second edge", alarm_irq, 1);

        // R9 sticky, write bit0 ignored, status read
        set_time(off_v);
        repeat (3) @(negedge clk);
        check("R9 sticky after mismatch", alarm_irq, 1);
        wr(7, 12'h001);
        check("R9 bit0 write keeps pending", alarm_irq, 1);
        rd(7, d); check("R9 status bit1", d, 12'h002);

        // R10 clear coincident with strobe and match
        tv = off_v; tv[0] = alm_v[0]; set_time(tv);
        @(negedge clk); sec_tick = 1; wr_en = 1; wr_addr = 7; wr_data = 12'h002;
        @(negedge clk); sec_tick = 0; wr_en = 0;
        check("R10 low after clear", alarm_irq, 0);
        @(negedge clk);
        check("R10 re-raised", alarm_irq, 1);
        wr(7, 12'h002);

        // R7 year hundreds digit
        tv = off_v; tv[5] = 12'h024; set_time(tv);
        wr(0, 12'h060);
        tick(); check("R7 hundreds mismatch", alarm_irq, 0);
        tv[5] = 12'h124; set_time(tv);
        tick(); check("R7 full year match", alarm_irq, 1);
        wr(7, 12'h002);

        // R8 month raw BCD
        wr(5, 12'h012);
        tv = off_v; tv[4] = 12'h012; set_time(tv);
        wr(0, 12'h050);
        tick(); check("R8 month 12 match", alarm_irq, 1);
        wr(7, 12'h002);
        tv[4] = 12'h011; set_time(tv);
        tick(); check("R8 month 11 mismatch", alarm_irq, 0);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule